// File: doc/BRIEF.md
# Dual-Thread Ping-Pong Buffer Writer

The block takes a stream of 32-bit words from a producer and lays them into two alternating buffer threads, 0 and 1. Each thread is a 16-word first-in first-out store that a consumer empties through its own drain request. The producer sees a valid/ready handshake: while the next thread is still held by the consumer, the block stalls the producer, and no word is lost.

A sequencer with four states decides where the stream goes. `ST_FILL0` and `ST_FILL1` fill a thread. `ST_SWITCH1` and `ST_SWITCH0` hand over to the other thread and wait until that thread reports ready. The transitions are:

- fill0→switch1 when a word is accepted while thread 0's watermark flag is high.
- switch1→fill1 when thread 1 is ready.
- fill1→switch0 when a word is accepted while thread 1's watermark flag is high.
- switch0→fill0 when thread 0 is ready.

The thread-select output is a register that follows the state one cycle late, so the word accepted in the first cycle after a state change still lands in the old thread. The watermark flag is therefore defined to lead the switch point. With a watermark of 1, every buffer is filled to the last word with no idle cycle. A word that reaches a thread that is not ready is discarded and sets a sticky overrun flag.

Top module: `pingpong_writer`

## Requirements
- R1: After reset the outputs are: active_thr is 0, thr_ready is 2'b11, thr_wm is 2'b00, overrun is 0 and in_ready is 1. Both buffers are empty.
- R2: thr_ready[n] goes low in the cycle after thread n's 16th stored word. It stays low until the consumer has popped all 16 words, and goes high in the cycle after the last pop. A thread holding fewer than 16 words stays ready.
- R3: thr_wm[n] is 1 exactly when active_thr equals n and (stored words of thread n + latched watermark) >= 15. This means the free space left after the word at the input is at most the watermark. The flag is combinational with no added latency.
- R4: In ST_FILL0/ST_FILL1, a word accepted while the active thread's thr_wm is high moves the sequencer to the switch state for the other thread.
- R5: active_thr is registered. It equals the target thread of the previous cycle's state (thread 0 for ST_FILL0/ST_SWITCH0, thread 1 for ST_FILL1/ST_SWITCH1). A word accepted in the first cycle after a state change goes to the previously active thread.
- R6: With the watermark at 1 and a word offered every cycle, 32 consecutive words are all accepted. Words 0..15 go to thread 0 and words 16..31 go to thread 1, with no overrun.
- R7: A switch state enters its fill state only when the target thread's thr_ready is 1. Once active_thr points to a thread that is not ready, in_ready is 0, so no word is taken. in_ready returns to 1 one cycle after the thread becomes ready.
- R8: A word accepted (in_valid and in_ready) while thr_ready[active_thr] is 0 is discarded and sets overrun. overrun stays 1 until cleared. With the watermark at 0, the 17th word of a continuous stream triggers this.
- R9: An err_clr pulse clears overrun on the next edge, unless a new overrun occurs in the same cycle.
- R10: wm_cfg is latched on the first clock edge after reset release and on any edge where wm_load is 1. Changes of wm_cfg at other times have no effect on thr_wm.
- R11: Each thread returns its words in write order on drain_data0/drain_data1. The oldest word is shown before the pop. A drain request on an empty thread is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; empties both buffers and selects thread 0 |
| in_data | input | 32 | Producer word |
| in_valid | input | 1 | Producer offers in_data |
| in_ready | output | 1 | Block takes the word this cycle |
| wm_cfg | input | 4 | Watermark in words |
| wm_load | input | 1 | Latch wm_cfg on this edge |
| drain_req | input | 2 | Per-thread pop request, bit n for thread n |
| err_clr | input | 1 | Synchronous clear of overrun |
| drain_data0 | output | 32 | Oldest word of thread 0 |
| drain_data1 | output | 32 | Oldest word of thread 1 |
| thr_ready | output | 2 | Per-thread ready flag |
| thr_wm | output | 2 | Per-thread watermark flag |
| active_thr | output | 1 | Thread currently written |
| overrun | output | 1 | Sticky write-overrun error |

## Verification
The assertions check the following on every cycle:
- A full buffer never reports ready.
- At most one watermark flag is high.
- A fill state always agrees with the selected thread.
- A rise of the select is always preceded by the switch state for thread 1.
- A switch state holds while its target is not ready.
- overrun stays sticky and clears on request.

Other properties need the bench's scenarios, because they depend on whole sequences rather than single cycles:
- The exact landing of the lagged word at the switch point.
- Gapless filling with a watermark of 1.
- The discarded 17th word with a watermark of 0.
- Write-order drain data.
- Watermark latching only on load.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [1:0] {
        ST_FILL0   = 2'd0,
        ST_FILL1   = 2'd1,
        ST_SWITCH0 = 2'd2,
        ST_SWITCH1 = 2'd3
    } seq_state_e;

    // Thread a state steers the (lagging) select register towards.
    function automatic logic target_thr(input seq_state_e s);
        return (s == ST_FILL1) || (s == ST_SWITCH1);
    endfunction

endpackage

// File: rtl/pp_wm_reg.sv
module pp_wm_reg #(
    parameter int WM_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WM_W-1:0] wm_cfg,
    input  logic            wm_load,
    output logic [WM_W-1:0] wm_q
);

    logic first_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_edge <= 1'b1;
            wm_q       <= '0;
        end else begin
            first_edge <= 1'b0;
            if (first_edge || wm_load) begin
                wm_q <= wm_cfg;
            end
        end
    end

endmodule

// File: rtl/pp_thread_buf.sv
module pp_thread_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int WM_W   = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic              is_active,
    input  logic [WM_W-1:0]   wm_q,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  fill,
    output logic              ready,
    output logic              wm_hit
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic              locked;
    logic              wr_ok, rd_ok;
    logic [CNT_W:0]    wm_sum;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        wr_ok  = wr_en && !locked;
        rd_ok  = rd_req && (cnt != '0);
        cnt_nx = cnt + CNT_W'(wr_ok) - CNT_W'(rd_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr   <= '0;
            rptr   <= '0;
            cnt    <= '0;
            locked <= 1'b0;
        end else begin
            if (wr_ok) wptr <= ptr_inc(wptr);
            if (rd_ok) rptr <= ptr_inc(rptr);
            cnt <= cnt_nx;
            if (cnt_nx == CNT_W'(DEPTH)) begin
                locked <= 1'b1;
            end else if (cnt_nx == '0) begin
                locked <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_data;
    end

    // Watermark leads the switch by one word to cover the lagging select.
    always_comb begin
        wm_sum  = {1'b0, cnt} + (CNT_W + 1)'(wm_q);
        wm_hit  = is_active && (wm_sum >= (CNT_W + 1)'(DEPTH - 1));
        rd_data = mem[rptr];
        fill    = cnt;
        ready   = !locked;
    end

endmodule

// File: rtl/pp_seq.sv
module pp_seq
    import pp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_acc,
    input  logic [1:0] thr_wm,
    input  logic [1:0] thr_ready,
    output seq_state_e state,
    output logic       sel,
    output logic       in_ready
);

    seq_state_e nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FILL0;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_FILL0:   if (wr_acc && thr_wm[0]) nxt = ST_SWITCH1;
            ST_FILL1:   if (wr_acc && thr_wm[1]) nxt = ST_SWITCH0;
            ST_SWITCH0: if (thr_ready[0])        nxt = ST_FILL0;
            ST_SWITCH1: if (thr_ready[1])        nxt = ST_FILL1;
            default:                             nxt = ST_FILL0;
        endcase
    end

    // Outputs: registered select, handshake from state and select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel <= 1'b0;
        else        sel <= target_thr(state);
    end

    always_comb begin
        unique case (state)
            ST_FILL0, ST_FILL1: in_ready = 1'b1;
            ST_SWITCH0:         in_ready = sel;
            ST_SWITCH1:         in_ready = !sel;
            default:            in_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/pingpong_writer.sv
module pingpong_writer
    import pp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int WM_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WM_W-1:0]   wm_cfg,
    input  logic              wm_load,
    input  logic [1:0]        drain_req,
    input  logic              err_clr,
    output logic [DATA_W-1:0] drain_data0,
    output logic [DATA_W-1:0] drain_data1,
    output logic [1:0]        thr_ready,
    output logic [1:0]        thr_wm,
    output logic              active_thr,
    output logic              overrun
);

    localparam int NUM_THR = 2;
    localparam int CNT_W   = $clog2(DEPTH + 1);

    if (((1 << WM_W) - 1) > DEPTH) begin : g_wm_range
        $error("watermark range exceeds buffer depth");
    end

    logic [WM_W-1:0]   wm_q;
    seq_state_e        seq_st;
    logic              sel;
    logic              wr_acc;
    logic [DATA_W-1:0] rd_data  [NUM_THR];
    logic [CNT_W-1:0]  fill_cnt [NUM_THR];

    pp_wm_reg #(.WM_W(WM_W)) u_wm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wm_cfg  (wm_cfg),
        .wm_load (wm_load),
        .wm_q    (wm_q)
    );

    pp_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_acc    (wr_acc),
        .thr_wm    (thr_wm),
        .thr_ready (thr_ready),
        .state     (seq_st),
        .sel       (sel),
        .in_ready  (in_ready)
    );

    assign wr_acc = in_valid && in_ready;

    for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
        pp_thread_buf #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH),
            .WM_W   (WM_W)
        ) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_acc && (sel == 1'(g))),
            .wr_data   (in_data),
            .rd_req    (drain_req[g]),
            .is_active (sel == 1'(g)),
            .wm_q      (wm_q),
            .rd_data   (rd_data[g]),
            .fill      (fill_cnt[g]),
            .ready     (thr_ready[g]),
            .wm_hit    (thr_wm[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (wr_acc && !thr_ready[sel]) begin
            overrun <= 1'b1;
        end else if (err_clr) begin
            overrun <= 1'b0;
        end
    end

    assign drain_data0 = rd_data[0];
    assign drain_data1 = rd_data[1];
    assign active_thr  = sel;

endmodule

// File: rtl/pp_writer_checks.sv
module pp_writer_checks
    import pp_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input seq_state_e       state,
    input logic             active_thr,
    input logic             in_valid,
    input logic             in_ready,
    input logic             err_clr,
    input logic             overrun,
    input logic [1:0]       thr_ready,
    input logic [1:0]       thr_wm,
    input logic [CNT_W-1:0] fill0,
    input logic [CNT_W-1:0] fill1
);

    a_r2_full_not_ready0: assert property (@(posedge clk) disable iff (!rst_n)
        (fill0 == CNT_W'(DEPTH)) |-> !thr_ready[0]);

    a_r2_full_not_ready1: assert property (@(posedge clk) disable iff (!rst_n)
        (fill1 == CNT_W'(DEPTH)) |-> !thr_ready[1]);

    a_r3_wm_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(thr_wm));

    a_r4_fill0_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL0) |-> (active_thr == 1'b0));

    a_r4_fill1_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL1) |-> (active_thr == 1'b1));

    a_r5_sel_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_thr) |-> ($past(state) == ST_SWITCH1));

    a_r7_wait_thr0: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWITCH0 && !thr_ready[0]) |=> (state == ST_SWITCH0));

    a_r7_wait_thr1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWITCH1 && !thr_ready[1]) |=> (state == ST_SWITCH1));

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !err_clr) |=> overrun);

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !(in_valid && in_ready && !thr_ready[active_thr])) |=> !overrun);

    a_r11_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (fill0 <= CNT_W'(DEPTH)) && (fill1 <= CNT_W'(DEPTH)));

endmodule

bind pingpong_writer pp_writer_checks #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (seq_st),
    .active_thr (active_thr),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .err_clr    (err_clr),
    .overrun    (overrun),
    .thr_ready  (thr_ready),
    .thr_wm     (thr_wm),
    .fill0      (fill_cnt[0]),
    .fill1      (fill_cnt[1])
);

// File: tb/test_pingpong_writer.sv
module test_pingpong_writer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  wm_cfg = 4'd1;
    logic        wm_load = 1'b0;
    logic [1:0]  drain_req = 2'b00;
    logic        err_clr = 1'b0;
    logic [31:0] drain_data0, drain_data1;
    logic [1:0]  thr_ready, thr_wm;
    logic        active_thr, overrun;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    pingpong_writer i_pingpong_writer (
        .clk (clk), .rst_n (rst_n),
        .in_data (in_data), .in_valid (in_valid), .in_ready (in_ready),
        .wm_cfg (wm_cfg), .wm_load (wm_load),
        .drain_req (drain_req), .err_clr (err_clr),
        .drain_data0 (drain_data0), .drain_data1 (drain_data1),
        .thr_ready (thr_ready), .thr_wm (thr_wm),
        .active_thr (active_thr), .overrun (overrun)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drain(input int thr, input int n, input logic [31:0] base,
                         input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            drain_req = (thr == 1) ? 2'b10 : 2'b01;
            #1;
            chk(req, "drain word", (thr == 1) ? drain_data1 : drain_data0,
                base + 32'(k));
        end
        @(negedge clk);
        drain_req = 2'b00;
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", "active_thr", 32'(active_thr), 32'd0);
        chk("R1", "thr_ready", 32'(thr_ready), 32'b11);
        chk("R1", "thr_wm", 32'(thr_wm), 32'b00);
        chk("R1", "overrun", 32'(overrun), 32'd0);
        chk("R1", "in_ready", 32'(in_ready), 32'd1);
    endtask

    // Watermark 1 latched at reset release: 32 words, no gap.
    task automatic t_gapless;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 32'h1000 + 32'(i);
            #1;
            chk("R6", "in_ready during stream", 32'(in_ready), 32'd1);
            if (i == 13) chk("R3", "thr_wm before mark", 32'(thr_wm), 32'b00);
            if (i == 14) chk("R10", "thr_wm at mark (wm from reset)", 32'(thr_wm), 32'b01);
            if (i == 15) chk("R5", "select lags switch", 32'(active_thr), 32'd0);
            if (i == 16) chk("R4", "switched to thread 1", 32'(active_thr), 32'd1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk("R6", "no overrun", 32'(overrun), 32'd0);
        chk("R2", "both full not ready", 32'(thr_ready), 32'b00);
        chk("R5", "select back on thread 0", 32'(active_thr), 32'd0);
        chk("R7", "producer stalled", 32'(in_ready), 32'd0);
        drain(0, 16, 32'h1000, "R11");
        chk("R2", "thread 0 ready after drain", 32'(thr_ready), 32'b01);
        chk("R7", "still waiting this cycle", 32'(in_ready), 32'd0);
        @(negedge clk);
        #1;
        chk("R7", "producer released", 32'(in_ready), 32'd1);
        @(negedge clk);
        drain_req = 2'b01;
        @(negedge clk);
        drain_req = 2'b00;
        #1;
        chk("R11", "empty pop ignored", 32'(thr_ready[0]), 32'd1);
        drain(1, 8, 32'h1010, "R11");
        chk("R2", "half drained not ready", 32'(thr_ready[1]), 32'd0);
        drain(1, 8, 32'h1018, "R11");
        chk("R2", "thread 1 ready after drain", 32'(thr_ready[1]), 32'd1);
    endtask

    // Watermark 0: the lagged 17th word overruns thread 0.
    task automatic t_overrun;
        @(negedge clk);
        wm_cfg  = 4'd0;
        wm_load = 1'b1;
        @(negedge clk);
        wm_load = 1'b0;
        wm_cfg  = 4'd5;
        for (int i = 0; i < 17; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 32'h2000 + 32'(i);
            #1;
            if (i == 10) chk("R10", "unloaded cfg ignored", 32'(thr_wm), 32'b00);
            if (i == 15) chk("R3", "thr_wm at wm 0", 32'(thr_wm), 32'b01);
            if (i == 16) chk("R8", "overrun not yet", 32'(overrun), 32'd0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk("R8", "overrun set", 32'(overrun), 32'd1);
        repeat (3) @(negedge clk);
        #1;
        chk("R8", "overrun sticky", 32'(overrun), 32'd1);
        drain(0, 16, 32'h2000, "R8");
        chk("R8", "discarded word not stored", 32'(thr_ready[0]), 32'd1);
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        #1;
        chk("R9", "overrun cleared", 32'(overrun), 32'd0);
    endtask

    // Watermark 4 on thread 1: early switch, partial buffer stays ready.
    task automatic t_wm4;
        @(negedge clk);
        wm_cfg  = 4'd4;
        wm_load = 1'b1;
        @(negedge clk);
        wm_load = 1'b0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 32'h3000 + 32'(i);
            #1;
            if (i == 10) chk("R3", "thr_wm below mark", 32'(thr_wm), 32'b00);
            if (i == 11) chk("R3", "thr_wm at mark 4", 32'(thr_wm), 32'b10);
            if (i == 12) chk("R5", "lagged word to thread 1", 32'(active_thr), 32'd1);
            if (i == 13) chk("R4", "switched to thread 0", 32'(active_thr), 32'd0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk("R2", "partial buffers ready", 32'(thr_ready), 32'b11);
        chk("R9", "no overrun", 32'(overrun), 32'd0);
        drain(1, 13, 32'h3000, "R5");
        drain(0, 1, 32'h300D, "R4");
    endtask

    initial begin
        t_reset();
        t_gapless();
        t_overrun();
        t_wm4();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule